// File: doc/BRIEF.md
# Sample Rate and Frame Sync Generator

This block makes the serial bit clock and the frame sync for a buffered audio serial port. It takes either every cycle of the module clock or the rising edges of an external clock pin as its source, counts a programmable number of source events per bit period, and drives a transmit and a receive bit clock from the result. From the bit clock edges it builds a frame sync pulse whose width and repeat period are programmed separately.

The frame pulse can run freely, repeating every frame, or be issued once for each transmit transfer request. The generator has two enables: one that lets the divider run and one that additionally lets frame pulses out. Each of the four outputs has its own polarity bit. All logic runs in the module clock domain; the bit clock is produced as a level computed from counters and registered once at the output, so every output changes one module clock after the counter state that causes it.

Top module: `smpl_fsync_gen`

## Requirements
- R1: While reset is asserted all four outputs are 0; once reset is released with the generator enable low, each output settles at its polarity bit.
- R2: With the source select bit (bit 29 of the configuration word) at 1, the bit clock repeats every D+1 module clocks and is high for ceil((D+1)/2) of them, where D is bits 7:0 and D is at least 1.
- R3: With the source select bit at 0, the divider counts rising edges of the external clock input, so the bit clock period is D+1 external clock periods.
- R4: With the mode bit (bit 28) at 1, the frame pulse is active during W+1 bit clock rising edges, starting on a bit clock rising edge, where W is bits 15:8 and W is below P.
- R5: In the mode of R4 a frame pulse starts every P+1 bit clock rising edges, where P is bits 27:16.
- R6: With the generator enable low the divider and frame state are held at zero and every output sits at its polarity bit; a running clock stops within two module clocks.
- R7: With the frame enable low the bit clocks run while both frame outputs stay inactive; once enabled, the first frame pulse begins on a bit clock rising edge.
- R8: Polarity bit 0 inverts the transmit clock, bit 1 the receive clock, bit 2 the transmit frame sync and bit 3 the receive frame sync; transmit and receive share the same nominal waveform.
- R9: With the mode bit at 0, a one-cycle transfer request produces exactly one frame pulse of W+1 bit clocks, starting at a bit clock edge no later than one bit period after the request.
- R10: A transfer request that arrives while a requested pulse is active, including in the cycle it ends or starts, is kept and served after exactly one inactive bit period.
- R11: With the mode bit at 1, transfer requests do not change the frame pulse width or period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External source clock pin, asynchronous |
| gen_en_i | input | 1 | Generator run enable |
| fs_en_i | input | 1 | Frame sync enable |
| xfer_req_i | input | 1 | Transmit transfer request, one module clock per request |
| gen_cfg_i | input | 30 | Divider [7:0], width [15:8], period [27:16], periodic mode [28], internal source [29] |
| pin_pol_i | input | 4 | Output inversion: tx clock, rx clock, tx frame, rx frame (bits 0..3) |
| tx_clk_o | output | 1 | Transmit bit clock |
| rx_clk_o | output | 1 | Receive bit clock |
| tx_fs_o | output | 1 | Transmit frame sync |
| rx_fs_o | output | 1 | Receive frame sync |

## Verification
The two functions that meet in one cycle are a new transfer request and the bit clock edge on which a requested pulse ends or a kept request starts its pulse. The bench provokes every alignment at once by holding the request high across whole pulses, so that a request is present in the end cycle, the start cycle and all cycles between. It judges the result from the ports by counting bit clock rising edges: each pulse must span W+1 of them and the gap between pulses must be exactly one.

// File: rtl/sfg_pkg.sv
// Package: shared encodings of the sample rate and frame sync generator.
// Assumes the configuration word is laid out divider, width, period,
// mode bit, source bit from the least significant end.
package sfg_pkg;

    localparam int NUM_PINS = 4;

    // Index of each output pin in the polarity vector.
    typedef enum logic [1:0] {
        PIN_TXC = 2'd0,
        PIN_RXC = 2'd1,
        PIN_TXF = 2'd2,
        PIN_RXF = 2'd3
    } pin_idx_e;

    // Divider source select.
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } src_sel_e;

    // Frame sync generation mode.
    typedef enum logic {
        FS_ON_REQUEST = 1'b0,
        FS_PERIODIC   = 1'b1
    } fs_mode_e;

endpackage

// File: rtl/sfg_src_sel.sv
// Module: source tick selection.
// Produces a one-cycle tick per divider source event: every module clock
// when the internal source is chosen, or one tick per rising edge of the
// external pin after a synchronizer chain. Assumes the external clock is
// slower than half the module clock.
module sfg_src_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_i,
    input  logic int_src_i,
    output logic tick_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               ext_rise;

    // Shift the external pin through the synchronizer plus one delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], ext_clk_i};
        end
    end

    // Rising edge of the synchronized pin.
    always_comb begin
        ext_rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
    end

    // Select the tick source.
    always_comb begin
        tick_o = int_src_i ? 1'b1 : ext_rise;
    end

endmodule

// File: rtl/sfg_bit_div.sv
// Module: bit clock divider.
// Counts source ticks from 0 to the divider value and reports a bit edge
// on the tick that wraps the count. The nominal clock level is high for
// the first ceil((D+1)/2) counts. Uses a greater-or-equal wrap so that a
// divider lowered mid-run cannot overrun.
module sfg_bit_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             edge_o,
    output logic             level_o,
    output logic [DIV_W-1:0] cnt_o
);
    localparam int HL_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q;
    logic [HL_W-1:0]  hi_len;

    // Bit edge: the source tick that completes a bit period.
    always_comb begin
        edge_o = run_i & tick_i & (cnt_q >= div_i);
    end

    // Length of the high phase in counts, rounded up.
    always_comb begin
        hi_len = ({1'b0, div_i} + HL_W'(2)) >> 1;
    end

    // Nominal clock level from the count.
    always_comb begin
        level_o = ({1'b0, cnt_q} < hi_len);
    end

    // Divider count: held at zero when cleared, wraps on a bit edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (edge_o) begin
            cnt_q <= '0;
        end else if (run_i && tick_i) begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sfg_frame.sv
// Module: frame sync former.
// Builds the nominal frame pulse from bit edges, either as a free-running
// frame of per+1 bit periods with a pulse of wid+1 bit periods, or as one
// pulse of wid+1 bit periods per transfer request. Assumes bit_edge_i is a
// single-cycle strobe and that ena_i already includes the generator enable.
module sfg_frame #(
    parameter int WID_W = 8,
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena_i,
    input  logic             bit_edge_i,
    input  logic             periodic_i,
    input  logic [WID_W-1:0] wid_i,
    input  logic [PER_W-1:0] per_i,
    input  logic             req_i,
    output logic             fs_o,
    output logic             run_o,
    output logic [PER_W-1:0] frm_cnt_o,
    output logic             shot_o,
    output logic             pend_o,
    output logic             shot_end_o
);
    localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    logic             run_q;
    logic [PER_W-1:0] frm_q;
    logic [WID_W-1:0] shot_cnt_q;
    logic             shot_q;
    logic             pend_q;
    logic             allow_shot;
    logic             shot_start;
    logic             shot_end;
    logic             in_width;

    // Frame running flag: set on the first bit edge after enabling.
    always_ff @(posedge clk) begin
        if (!rst_n || !ena_i) begin
            run_q <= 1'b0;
        end else if (bit_edge_i) begin
            run_q <= 1'b1;
        end
    end

    // Periodic frame position, wraps after per_i.
    always_ff @(posedge clk) begin
        if (!rst_n || !ena_i || !periodic_i) begin
            frm_q <= '0;
        end else if (run_q && bit_edge_i) begin
            frm_q <= (frm_q >= per_i) ? '0 : frm_q + PER_W'(1);
        end
    end

    // Position lies inside the pulse width.
    always_comb begin
        in_width = (CMP_W'(frm_q) <= CMP_W'(wid_i));
    end

    // Request-driven pulse controls.
    always_comb begin
        allow_shot = ena_i & ~periodic_i;
        shot_start = run_q & bit_edge_i & pend_q & ~shot_q;
        shot_end   = shot_q & bit_edge_i & (shot_cnt_q >= wid_i);
    end

    // Pending request: kept until a pulse starts, new requests always kept.
    always_ff @(posedge clk) begin
        if (!rst_n || !allow_shot) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~shot_start) | req_i;
        end
    end

    // Requested pulse active flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !allow_shot) begin
            shot_q <= 1'b0;
        end else if (shot_start) begin
            shot_q <= 1'b1;
        end else if (shot_end) begin
            shot_q <= 1'b0;
        end
    end

    // Bit periods elapsed inside a requested pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !allow_shot || shot_start) begin
            shot_cnt_q <= '0;
        end else if (shot_q && bit_edge_i) begin
            shot_cnt_q <= shot_end ? '0 : shot_cnt_q + WID_W'(1);
        end
    end

    // Nominal frame level for the selected mode.
    always_comb begin
        fs_o = periodic_i ? (run_q & in_width) : shot_q;
    end

    assign run_o      = run_q;
    assign frm_cnt_o  = frm_q;
    assign shot_o     = shot_q;
    assign pend_o     = pend_q;
    assign shot_end_o = shot_end;

endmodule

// File: rtl/sfg_out_reg.sv
// Module: output polarity stage.
// Registers each nominal output XOR its polarity bit so the pins change
// only on module clock edges. Reset drives every pin low.
module sfg_out_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] pin_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        // One registered, polarity-adjusted pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pin_o[g] <= 1'b0;
            end else begin
                pin_o[g] <= raw_i[g] ^ pol_i[g];
            end
        end
    end

endmodule

// File: rtl/smpl_fsync_gen.sv
// Module: sample rate and frame sync generator, top level.
// Decodes the configuration word, runs the divider from the selected
// source, forms the frame pulse and drives four polarity-adjusted pins.
// Assumes the configuration is stable or changed only with the generator
// disabled when exact frame timing matters.
module smpl_fsync_gen
    import sfg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int WID_W       = 8,
    parameter int PER_W       = 12,
    parameter int SYNC_STAGES = 2,
    localparam int WID_LSB    = DIV_W,
    localparam int PER_LSB    = DIV_W + WID_W,
    localparam int MODE_BIT   = PER_LSB + PER_W,
    localparam int SRC_BIT    = MODE_BIT + 1,
    localparam int CFG_W      = SRC_BIT + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_clk_i,
    input  logic                gen_en_i,
    input  logic                fs_en_i,
    input  logic                xfer_req_i,
    input  logic [CFG_W-1:0]    gen_cfg_i,
    input  logic [NUM_PINS-1:0] pin_pol_i,
    output logic                tx_clk_o,
    output logic                rx_clk_o,
    output logic                tx_fs_o,
    output logic                rx_fs_o
);
    logic [DIV_W-1:0]    div_val;
    logic [WID_W-1:0]    wid_val;
    logic [PER_W-1:0]    per_val;
    logic                periodic;
    logic                int_src;
    logic                run_q;
    logic                gen_act;
    logic                src_tick;
    logic                bit_edge;
    logic                bit_level;
    logic [DIV_W-1:0]    div_cnt;
    logic                fs_raw;
    logic                fs_run;
    logic [PER_W-1:0]    frm_cnt;
    logic                shot_on;
    logic                pending;
    logic                shot_end;
    logic [NUM_PINS-1:0] raw_vec;
    logic [NUM_PINS-1:0] pin_vec;

    // Field decode of the configuration word.
    always_comb begin
        div_val  = gen_cfg_i[DIV_W-1:0];
        wid_val  = gen_cfg_i[WID_LSB +: WID_W];
        per_val  = gen_cfg_i[PER_LSB +: PER_W];
        periodic = (fs_mode_e'(gen_cfg_i[MODE_BIT]) == FS_PERIODIC);
        int_src  = (src_sel_e'(gen_cfg_i[SRC_BIT]) == SRC_INT);
    end

    // Generator running flag, one cycle behind the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else begin
            run_q <= gen_en_i;
        end
    end

    // Counters advance only once running and still enabled.
    always_comb begin
        gen_act = run_q & gen_en_i;
    end

    sfg_src_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_clk_i),
        .int_src_i (int_src),
        .tick_o    (src_tick)
    );

    sfg_bit_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (gen_act),
        .clear_i (~gen_en_i),
        .tick_i  (src_tick),
        .div_i   (div_val),
        .edge_o  (bit_edge),
        .level_o (bit_level),
        .cnt_o   (div_cnt)
    );

    sfg_frame #(
        .WID_W (WID_W),
        .PER_W (PER_W)
    ) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ena_i      (gen_en_i & fs_en_i),
        .bit_edge_i (bit_edge),
        .periodic_i (periodic),
        .wid_i      (wid_val),
        .per_i      (per_val),
        .req_i      (xfer_req_i),
        .fs_o       (fs_raw),
        .run_o      (fs_run),
        .frm_cnt_o  (frm_cnt),
        .shot_o     (shot_on),
        .pend_o     (pending),
        .shot_end_o (shot_end)
    );

    // Nominal waveforms: transmit and receive share clock and frame.
    always_comb begin
        raw_vec          = '0;
        raw_vec[PIN_TXC] = run_q & bit_level;
        raw_vec[PIN_RXC] = run_q & bit_level;
        raw_vec[PIN_TXF] = fs_raw;
        raw_vec[PIN_RXF] = fs_raw;
    end

    sfg_out_reg #(
        .N (NUM_PINS)
    ) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw_vec),
        .pol_i (pin_pol_i),
        .pin_o (pin_vec)
    );

    assign tx_clk_o = pin_vec[PIN_TXC];
    assign rx_clk_o = pin_vec[PIN_RXC];
    assign tx_fs_o  = pin_vec[PIN_TXF];
    assign rx_fs_o  = pin_vec[PIN_RXF];

endmodule

// File: rtl/sfg_chk.sv
// Module: assertion checker for the sample rate and frame sync generator.
// Observes pins and internal counter state; bound into the top below.
module sfg_chk #(
    parameter int DIV_W = 8,
    parameter int PER_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gen_en_i,
    input logic             fs_en_i,
    input logic [3:0]       pin_pol_i,
    input logic             tx_clk_o,
    input logic             rx_clk_o,
    input logic             tx_fs_o,
    input logic             rx_fs_o,
    input logic             run_q,
    input logic             bit_edge,
    input logic [DIV_W-1:0] div_cnt,
    input logic [DIV_W-1:0] div_val,
    input logic [PER_W-1:0] frm_cnt,
    input logic             fs_run,
    input logic             shot_on,
    input logic             pending,
    input logic             shot_end,
    input logic             fs_raw
);
    // R6: disabling the generator clears all counting state.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en_i |=> (div_cnt == '0 && frm_cnt == '0 && !shot_on && !pending));

    // R6 and R8: a stopped generator leaves the pins at their polarity bits.
    p_idle_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |=> (tx_clk_o == $past(pin_pol_i[0]) && tx_fs_o == $past(pin_pol_i[2])));

    // R2: a bit edge restarts the divider count.
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge |=> (div_cnt == '0));

    // R2: with a nonzero divider, bit edges never fall in adjacent cycles.
    p_edge_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_edge && div_val != '0) |=> (!bit_edge || div_val == '0));

    // R7: a cleared frame enable silences the frame level.
    p_fs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fs_en_i |=> !fs_raw);

    // R7: a frame starts at position zero on a bit edge.
    p_fs_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_run) |-> (frm_cnt == '0 && $past(bit_edge)));

    // R8: the two clock pins differ exactly by their polarity bits.
    p_clk_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_clk_o ^ rx_clk_o) == $past(pin_pol_i[0] ^ pin_pol_i[1])));

    // R8: the two frame pins differ exactly by their polarity bits.
    p_fs_pol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((tx_fs_o ^ rx_fs_o) == $past(pin_pol_i[2] ^ pin_pol_i[3])));

    // R10: a requested pulse is always followed by an inactive bit period.
    p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        shot_end |=> !shot_on);

endmodule

bind smpl_fsync_gen sfg_chk #(
    .DIV_W (DIV_W),
    .PER_W (PER_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en_i  (gen_en_i),
    .fs_en_i   (fs_en_i),
    .pin_pol_i (pin_pol_i),
    .tx_clk_o  (tx_clk_o),
    .rx_clk_o  (rx_clk_o),
    .tx_fs_o   (tx_fs_o),
    .rx_fs_o   (rx_fs_o),
    .run_q     (run_q),
    .bit_edge  (bit_edge),
    .div_cnt   (div_cnt),
    .div_val   (div_val),
    .frm_cnt   (frm_cnt),
    .fs_run    (fs_run),
    .shot_on   (shot_on),
    .pending   (pending),
    .shot_end  (shot_end),
    .fs_raw    (fs_raw)
);

// File: tb/sim_smpl_fsync_gen.sv
// Bench: self-checking test of the sample rate and frame sync generator.
// Measures periods and pulse widths at the pins and compares them with
// values computed from the requirements.
module sim_smpl_fsync_gen;

    localparam int LIM = 20000;
    localparam int WD  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        fs_en = 1'b0;
    logic        xfer_req = 1'b0;
    logic [29:0] gen_cfg = '0;
    logic [3:0]  pin_pol = '0;
    logic        ext_clk;
    logic        tx_clk, rx_clk, tx_fs, rx_fs;

    int  ext_per = 3;
    int  ext_ph = 0;
    int  vecs = 0;
    int  bad = 0;
    bit  done = 1'b0;
    bit  cur_c, cur_f, last_c, last_f, rise_c, rise_f;

    always #10 clk = ~clk;

    // External source: one high cycle every ext_per module clocks.
    always @(negedge clk) ext_ph <= (ext_ph + 1 >= ext_per) ? 0 : ext_ph + 1;
    assign ext_clk = (ext_ph == 0);

    smpl_fsync_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_clk_i  (ext_clk),
        .gen_en_i   (gen_en),
        .fs_en_i    (fs_en),
        .xfer_req_i (xfer_req),
        .gen_cfg_i  (gen_cfg),
        .pin_pol_i  (pin_pol),
        .tx_clk_o   (tx_clk),
        .rx_clk_o   (rx_clk),
        .tx_fs_o    (tx_fs),
        .rx_fs_o    (rx_fs)
    );

    function automatic logic [29:0] cfg_word(bit src, bit mode, int p, int w, int d);
        return {src, mode, 12'(p), 8'(w), 8'(d)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cur_c  = tx_clk;
        cur_f  = tx_fs;
        rise_c = cur_c & ~last_c;
        rise_f = cur_f & ~last_f;
        last_c = cur_c;
        last_f = cur_f;
    endtask

    task automatic restart(logic [29:0] cfg, bit fse);
        gen_en = 1'b0;
        fs_en  = 1'b0;
        repeat (3) step();
        gen_cfg = cfg;
        gen_en  = 1'b1;
        fs_en   = fse;
        step();
    endtask

    task automatic meas_bclk(output int per, output int hi);
        int k = 0;
        do begin step(); k++; end while (!rise_c && k < LIM);
        per = 0;
        hi  = 1;
        for (int i = 0; i < LIM; i++) begin
            step();
            per++;
            if (rise_c) break;
            if (cur_c) hi++;
        end
    endtask

    task automatic meas_frame(output int w, output int p);
        int k = 0;
        do begin step(); k++; end while (!rise_f && k < LIM);
        w = 1;
        p = 0;
        for (int i = 0; i < LIM; i++) begin
            step();
            if (rise_c) begin
                p++;
                if (rise_f) break;
                if (cur_f) w++;
            end
        end
    endtask

    initial begin
        int per, hi, w, p, d, wd, pd, cnt, miss;
        void'($urandom(32'd4711));

        // R1: reset state of the pins, then idle levels equal polarity bits.
        pin_pol = 4'b1010;
        repeat (3) step();
        chk("R1 reset pins", {rx_fs, tx_fs, rx_clk, tx_clk}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        chk("R1 idle pins", {rx_fs, tx_fs, rx_clk, tx_clk}, 4'b1010);
        pin_pol = 4'b0000;

        // R2 and R4 and R5: random internal-source configurations.
        for (int t = 0; t < 6; t++) begin
            d  = 1 + int'($urandom % 8);
            wd = int'($urandom % 5);
            pd = wd + 1 + int'($urandom % 8);
            restart(cfg_word(1'b1, 1'b1, pd, wd, d), 1'b1);
            meas_bclk(per, hi);
            chk("R2 bit period", per, d + 1);
            chk("R2 high phase", hi, (d + 2) / 2);
            meas_frame(w, p);
            chk("R4 pulse width", w, wd + 1);
            chk("R5 frame period", p, pd + 1);
        end

        // R4 and R5 corner: single-bit pulse in the shortest frame, divider 1.
        restart(cfg_word(1'b1, 1'b1, 1, 0, 1), 1'b1);
        meas_frame(w, p);
        chk("R4 min width", w, 1);
        chk("R5 min period", p, 2);

        // R3: external source at one edge per three module clocks.
        ext_per = 3;
        for (int t = 0; t < 2; t++) begin
            d = 1 + int'($urandom % 5);
            restart(cfg_word(1'b0, 1'b1, 6, 2, d), 1'b1);
            repeat (8) step();
            meas_bclk(per, hi);
            chk("R3 ext bit period", per, 3 * (d + 1));
        end

        // R11: requests held high in periodic mode change nothing.
        restart(cfg_word(1'b1, 1'b1, 7, 2, 2), 1'b1);
        xfer_req = 1'b1;
        meas_frame(w, p);
        chk("R11 width with requests", w, 3);
        chk("R11 period with requests", p, 8);
        xfer_req = 1'b0;

        // R7: frame enable low keeps frame pins idle while clocks run.
        restart(cfg_word(1'b1, 1'b1, 5, 1, 2), 1'b0);
        cnt = 0;
        miss = 0;
        for (int i = 0; i < 100; i++) begin
            step();
            if (rise_c) cnt++;
            if (cur_f || rx_fs) miss++;
        end
        chk("R7 frame idle", miss, 0);
        chk("R7 clock runs", int'(cnt > 0), 1);
        fs_en = 1'b1;
        miss = 1;
        for (int i = 0; i < LIM; i++) begin
            step();
            if (rise_f) begin miss = rise_c ? 0 : 2; break; end
        end
        chk("R7 first pulse on clock edge", miss, 0);

        // R8: transmit clock and frame inverted, receive pins nominal.
        pin_pol = 4'b0101;
        step();
        step();
        miss = 0;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            step();
            if (tx_clk == rx_clk) miss++;
            if (tx_fs == rx_fs) miss++;
            if (rx_fs) cnt++;
        end
        chk("R8 inverted pairs", miss, 0);
        chk("R8 rx frame pulses", int'(cnt > 0), 1);

        // R6: disabling the generator parks every pin at its polarity bit.
        pin_pol = 4'b0110;
        gen_en  = 1'b0;
        step();
        step();
        miss = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if ({rx_fs, tx_fs, rx_clk, tx_clk} != 4'b0110) miss++;
        end
        chk("R6 parked pins", miss, 0);
        pin_pol = 4'b0000;

        // R9: one request gives one pulse of W+1 bit clocks, promptly.
        restart(cfg_word(1'b1, 1'b0, 9, 3, 2), 1'b1);
        repeat (12) step();
        xfer_req = 1'b1;
        step();
        xfer_req = 1'b0;
        cnt = 0;
        w = 0;
        p = -1;
        for (int i = 1; i <= 60; i++) begin
            step();
            if (rise_f) begin cnt++; if (p < 0) p = i; end
            if (rise_c && cur_f) w++;
        end
        chk("R9 pulse count", cnt, 1);
        chk("R9 pulse width", w, 4);
        chk("R9 start delay bound", int'(p > 0 && p <= 4), 1);

        // R10: requests held across pulse end and start: one-bit gap each time.
        restart(cfg_word(1'b1, 1'b0, 9, 2, 3), 1'b1);
        xfer_req = 1'b1;
        for (int t = 0; t < 3; t++) begin
            meas_frame(w, p);
            chk("R10 pulse width", w, 3);
            chk("R10 one-bit gap", p - w, 1);
        end
        xfer_req = 1'b0;

        // R10 with a single-bit pulse width.
        restart(cfg_word(1'b1, 1'b0, 9, 0, 1), 1'b1);
        xfer_req = 1'b1;
        meas_frame(w, p);
        chk("R10 narrow width", w, 1);
        chk("R10 narrow gap", p - w, 1);
        xfer_req = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

endmodule